// File: doc/BRIEF.md
# Multi-Window Message Drain Sequencer

This block empties a group of adjacent mailbox windows that together carry one multi-word message. A command gives the index of the first window and the number of windows in the group. The sequencer then walks the group from the lowest window to the highest. For each window it reads the raw status word and then writes all-ones to that window's clear register. It issues one register-bus transaction at a time and waits for the acknowledge before it issues the next.

The sender fills the highest window of the group last, and only that window is left unmasked, so it alone raises the receive interrupt. The sequencer clears that window as its final bus operation. The interrupt therefore falls only once every word has been taken. The captured words are handed downstream in reversed window order, so the highest window becomes word 0. Each word goes out on a valid/ready port together with the message length in bytes.

Two further commands prepare and retire the channel. One unmasks only the last window of the group by writing all-ones to its mask-clear register. The other re-masks that window through its mask-set register.

Top module: `mbx_drain_engine`

## Requirements
- R1: After reset, `busy`, `bus_req` and `out_valid` are low.
- R2: A drain command (`cmd_op` = 0) reads windows `cmd_base` through `cmd_base+cmd_count-1` in ascending order. Each read uses register select 0, which is the raw (unmasked) status.
- R3: Each read is followed directly by a write of all-ones, with register select 1 (clear), to the same window. A drain of W windows issues exactly 2·W bus transactions, and the clear of the last window is the final one.
- R4: Output word p equals the status read from window `cmd_base+W-1-p`, for p = 0 … W-1. `out_last` is high only with word W-1, and `msg_bytes` equals 4·W while the words are presented.
- R5: Only one bus transaction is outstanding at a time. `bus_req`, `bus_win` and `bus_sel` stay constant until `bus_ack` is seen.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: `busy` is high from the cycle after a command is accepted until the last word has been taken. A command presented while `busy` is high is ignored and causes no bus transaction. No bus transaction occurs while words are being delivered.
- R8: An unmask command (`cmd_op` = 1) issues one bus write of all-ones, with register select 3 (mask-clear), to window `cmd_base+cmd_count-1` only.
- R9: A mask command (`cmd_op` = 2) issues one bus write of all-ones, with register select 2 (mask-set), to window `cmd_base+cmd_count-1` only.
- R10: A command is rejected if its count is 0, its count exceeds `MAX_WIN`, `cmd_base+cmd_count` exceeds `NUM_WIN`, or its `cmd_op` is 3. A rejected command starts no bus transaction and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | 0 drain, 1 unmask last window, 2 mask last window |
| cmd_base | input | $clog2(NUM_WIN) | First window of the group |
| cmd_count | input | $clog2(MAX_WIN+1) | Number of windows in the group |
| busy | output | 1 | Command in progress |
| bus_req | output | 1 | Register-bus request |
| bus_sel | output | 2 | Register select: 0 raw status, 1 clear, 2 mask-set, 3 mask-clear |
| bus_win | output | $clog2(NUM_WIN) | Window index of the transaction |
| bus_wdata | output | DATA_W | Write data (all-ones for writes) |
| bus_ack | input | 1 | Transaction completes in this cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| out_valid | output | 1 | Message word available |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DATA_W | Message word |
| out_last | output | 1 | Final word of the message |
| msg_bytes | output | $clog2(MAX_WIN*DATA_W/8+1) | Message length in bytes |

## Verification
A command is taken at a clock edge, and its first bus request appears in the next cycle. Each bus step then completes on the edge where `bus_ack` is high, and the first word is offered in the cycle after the last clear is acknowledged. Because the slave in the bench stalls at random, the bench never counts fixed delays. It sets `out_ready` at the falling edge, samples outputs a moment later, and compares the log of acknowledged bus transactions against the expected order once the final word has been taken. `busy` is checked one falling edge after that final handshake.

// File: rtl/mbx_drain_pkg.sv
package mbx_drain_pkg;

   // register selects on the bus toward the mailbox core
   typedef enum logic [1:0] {
      SEL_RAW  = 2'd0,
      SEL_CLR  = 2'd1,
      SEL_MSET = 2'd2,
      SEL_MCLR = 2'd3
   } sel_e;

   // command opcodes
   typedef enum logic [1:0] {
      OP_DRAIN  = 2'd0,
      OP_UNMASK = 2'd1,
      OP_MASK   = 2'd2,
      OP_NONE   = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_CLEAR,
      ST_CTRL,
      ST_STREAM
   } st_e;

endpackage

// File: rtl/mbx_drain_buf.sv
module mbx_drain_buf #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [POS_W-1:0]  wr_pos,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [POS_W-1:0]  rd_pos,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] word_q [DEPTH];

   // one register per message slot
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[g] <= '0;
         else if (wr_en && wr_pos == POS_W'(g))
            word_q[g] <= wr_data;
      end
   end

   assign rd_data = word_q[rd_pos];

endmodule

// File: rtl/mbx_drain_seq.sv
module mbx_drain_seq
   import mbx_drain_pkg::*;
#(
   parameter int NUM_WIN = 16,
   parameter int MAX_WIN = 8,
   parameter int DATA_W  = 32,
   localparam int WIN_W  = $clog2(NUM_WIN),
   localparam int CNT_W  = $clog2(MAX_WIN + 1),
   localparam int POS_W  = $clog2(MAX_WIN),
   localparam int LEN_W  = $clog2(MAX_WIN * DATA_W / 8 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WIN_W-1:0]  cmd_base,
   input  logic [CNT_W-1:0]  cmd_count,
   output logic              busy,
   output logic              bus_req,
   output logic [1:0]        bus_sel,
   output logic [WIN_W-1:0]  bus_win,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              buf_wr_en,
   output logic [POS_W-1:0]  buf_wr_pos,
   output logic [DATA_W-1:0] buf_wr_data,
   output logic [POS_W-1:0]  buf_rd_pos,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_last,
   output logic [LEN_W-1:0]  msg_bytes
);

   st_e              state_q;
   sel_e             ctrl_sel_q;
   logic [WIN_W-1:0] base_q;
   logic [CNT_W-1:0] cnt_q;
   logic [POS_W-1:0] idx_q;
   logic [POS_W-1:0] pos_q;

   op_e  op_in;
   logic cnt_ok, range_ok, cmd_ok, accept, idx_last;
   logic [WIN_W-1:0] last_win;

   assign op_in    = op_e'(cmd_op);
   assign cnt_ok   = (cmd_count != '0) && (cmd_count <= CNT_W'(MAX_WIN));
   assign range_ok = ({1'b0, cmd_base} + (WIN_W+1)'(cmd_count)) <= (WIN_W+1)'(NUM_WIN);
   assign cmd_ok   = cnt_ok && range_ok && (op_in != OP_NONE);
   assign accept   = cmd_valid && (state_q == ST_IDLE) && cmd_ok;

   assign last_win = base_q + WIN_W'(cnt_q) - WIN_W'(1);
   assign idx_last = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ctrl_sel_q <= SEL_MCLR;
         base_q     <= '0;
         cnt_q      <= '0;
         idx_q      <= '0;
         pos_q      <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               base_q <= cmd_base;
               cnt_q  <= cmd_count;
               idx_q  <= '0;
               pos_q  <= '0;
               case (op_in)
                  OP_DRAIN:  state_q <= ST_READ;
                  OP_UNMASK: begin ctrl_sel_q <= SEL_MCLR; state_q <= ST_CTRL; end
                  default:   begin ctrl_sel_q <= SEL_MSET; state_q <= ST_CTRL; end
               endcase
            end
            ST_READ:  if (bus_ack) state_q <= ST_CLEAR;
            ST_CLEAR: if (bus_ack) begin
               if (idx_last) state_q <= ST_STREAM;
               else begin
                  idx_q   <= idx_q + POS_W'(1);
                  state_q <= ST_READ;
               end
            end
            ST_CTRL:  if (bus_ack) state_q <= ST_IDLE;
            ST_STREAM: if (out_ready) begin
               if (out_last) state_q <= ST_IDLE;
               else          pos_q   <= pos_q + POS_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // bus master side
   always_comb begin
      bus_req   = 1'b0;
      bus_sel   = SEL_RAW;
      bus_win   = base_q + WIN_W'(idx_q);
      bus_wdata = '0;
      case (state_q)
         ST_READ:  bus_req = 1'b1;
         ST_CLEAR: begin bus_req = 1'b1; bus_sel = SEL_CLR; bus_wdata = '1; end
         ST_CTRL:  begin bus_req = 1'b1; bus_sel = ctrl_sel_q; bus_win = last_win; bus_wdata = '1; end
         default:  ;
      endcase
   end

   // reversed placement: window base+i lands at slot W-1-i
   assign buf_wr_en   = (state_q == ST_READ) && bus_ack;
   assign buf_wr_pos  = POS_W'(cnt_q - CNT_W'(1) - CNT_W'(idx_q));
   assign buf_wr_data = bus_rdata;
   assign buf_rd_pos  = pos_q;

   assign busy      = (state_q != ST_IDLE);
   assign out_valid = (state_q == ST_STREAM);
   assign out_last  = (CNT_W'(pos_q) == cnt_q - CNT_W'(1));
   assign msg_bytes = LEN_W'(cnt_q) * LEN_W'(DATA_W / 8);

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_win) && $stable(bus_sel)); // R5

   AST_CLEAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_sel == SEL_RAW |=> bus_req && bus_sel == SEL_CLR && bus_win == $past(bus_win)); // R3

   AST_WRITE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_sel != SEL_RAW |-> bus_wdata == {DATA_W{1'b1}}); // R3

   AST_NEXT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_CLEAR && bus_ack && !idx_last |=> bus_req && bus_sel == SEL_RAW && bus_win == $past(bus_win) + WIN_W'(1)); // R2

   AST_BAD_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && cmd_valid && !cmd_ok |=> !busy && !bus_req); // R10

   AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_valid |=> $stable(base_q) && $stable(cnt_q)); // R7

   AST_STREAM_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !bus_req); // R7

endmodule

// File: rtl/mbx_drain_engine.sv
module mbx_drain_engine
   import mbx_drain_pkg::*;
#(
   parameter int NUM_WIN = 16,
   parameter int MAX_WIN = 8,
   parameter int DATA_W  = 32,
   localparam int WIN_W  = $clog2(NUM_WIN),
   localparam int CNT_W  = $clog2(MAX_WIN + 1),
   localparam int POS_W  = $clog2(MAX_WIN),
   localparam int LEN_W  = $clog2(MAX_WIN * DATA_W / 8 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [WIN_W-1:0]  cmd_base,
   input  logic [CNT_W-1:0]  cmd_count,
   output logic              busy,
   output logic              bus_req,
   output logic [1:0]        bus_sel,
   output logic [WIN_W-1:0]  bus_win,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic [LEN_W-1:0]  msg_bytes
);

   // elaboration-time parameter checks
   if (NUM_WIN < 2) begin : g_chk_num
      $error("NUM_WIN must be at least 2");
   end
   if (MAX_WIN < 2 || MAX_WIN > NUM_WIN) begin : g_chk_max
      $error("MAX_WIN must lie in 2..NUM_WIN");
   end
   if (DATA_W % 8 != 0) begin : g_chk_data
      $error("DATA_W must be a whole number of bytes");
   end

   logic              buf_wr_en;
   logic [POS_W-1:0]  buf_wr_pos;
   logic [DATA_W-1:0] buf_wr_data;
   logic [POS_W-1:0]  buf_rd_pos;

   mbx_drain_seq #(
      .NUM_WIN(NUM_WIN),
      .MAX_WIN(MAX_WIN),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_base   (cmd_base),
      .cmd_count  (cmd_count),
      .busy       (busy),
      .bus_req    (bus_req),
      .bus_sel    (bus_sel),
      .bus_win    (bus_win),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata),
      .buf_wr_en  (buf_wr_en),
      .buf_wr_pos (buf_wr_pos),
      .buf_wr_data(buf_wr_data),
      .buf_rd_pos (buf_rd_pos),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_last   (out_last),
      .msg_bytes  (msg_bytes)
   );

   mbx_drain_buf #(
      .DEPTH (MAX_WIN),
      .DATA_W(DATA_W),
      .POS_W (POS_W)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (buf_wr_en),
      .wr_pos (buf_wr_pos),
      .wr_data(buf_wr_data),
      .rd_pos (buf_rd_pos),
      .rd_data(out_data)
   );

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6

   AST_SINGLE_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> bus_req && !out_valid); // R5

endmodule

// File: tb/mbx_drain_engine_test.sv
`timescale 1ns/1ps
module mbx_drain_engine_test;

   localparam int NUM_WIN = 16;
   localparam int MAX_WIN = 8;
   localparam int DATA_W  = 32;
   localparam int WIN_W   = $clog2(NUM_WIN);
   localparam int CNT_W   = $clog2(MAX_WIN + 1);
   localparam int LEN_W   = $clog2(MAX_WIN * DATA_W / 8 + 1);
   localparam logic [31:0] ONES = 32'hFFFF_FFFF;

   // vector table: {base, count, ready pattern, stall enable}
   localparam int VEC_N = 6;
   localparam logic [20:0] VECS [VEC_N] = '{
      {5'd0,  4'd1, 8'hFF, 4'd0},
      {5'd3,  4'd4, 8'hB5, 4'd1},
      {5'd8,  4'd8, 8'hFF, 4'd1},
      {5'd15, 4'd1, 8'h33, 4'd1},
      {5'd10, 4'd6, 8'h6D, 4'd0},
      {5'd2,  4'd3, 8'h81, 4'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = 2'd0;
   logic [WIN_W-1:0]  cmd_base = '0;
   logic [CNT_W-1:0]  cmd_count = '0;
   logic              busy, bus_req, bus_ack, out_valid, out_last;
   logic              out_ready = 1'b0;
   logic [1:0]        bus_sel;
   logic [WIN_W-1:0]  bus_win;
   logic [DATA_W-1:0] bus_wdata, bus_rdata, out_data;
   logic [LEN_W-1:0]  msg_bytes;

   mbx_drain_engine #(.NUM_WIN(NUM_WIN), .MAX_WIN(MAX_WIN), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_base(cmd_base), .cmd_count(cmd_count), .busy(busy),
      .bus_req(bus_req), .bus_sel(bus_sel), .bus_win(bus_win),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .msg_bytes(msg_bytes)
   );

   // behavioural mailbox core
   logic [31:0] stat_mem [NUM_WIN];
   logic [31:0] mask_mem [NUM_WIN];
   int          log_win [512];
   int          log_sel [512];
   logic [31:0] log_wd  [512];
   int          log_n = 0;
   logic [7:0]  lfsr = 8'h5B;
   logic        stall_en = 1'b0;

   assign bus_ack   = bus_req && (!stall_en || lfsr[0]);
   assign bus_rdata = stat_mem[bus_win];

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (bus_req && bus_ack) begin
         log_win[log_n] <= int'(bus_win);
         log_sel[log_n] <= int'(bus_sel);
         log_wd[log_n]  <= bus_wdata;
         log_n <= log_n + 1;
         case (bus_sel)
            2'd1: stat_mem[bus_win] <= stat_mem[bus_win] & ~bus_wdata;
            2'd2: mask_mem[bus_win] <= mask_mem[bus_win] | bus_wdata;
            2'd3: mask_mem[bus_win] <= mask_mem[bus_win] & ~bus_wdata;
            default: ;
         endcase
      end
   end

   int chk_cnt = 0;
   int fail_cnt = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      chk_cnt++;
      if (!ok) begin
         fail_cnt++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input int base, input int cnt);
      @(negedge clk);
      cmd_op = op; cmd_base = WIN_W'(base); cmd_count = CNT_W'(cnt); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run_drain(input int base, input int cnt, input logic [7:0] pat, input int tag);
      logic [31:0] expw [MAX_WIN];
      int start, got, cyc;
      for (int w = 0; w < cnt; w++) begin
         stat_mem[base + w] = {8'hA5, 8'(tag), 8'(base + w), 8'h5A};
      end
      for (int p = 0; p < cnt; p++) expw[p] = stat_mem[base + cnt - 1 - p];
      start = log_n;
      issue(2'd0, base, cnt);
      check(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
      got = 0; cyc = 0;
      while (got < cnt && cyc < 3000) begin
         @(negedge clk);
         out_ready = pat[cyc % 8];
         cyc++;
         #1;
         if (out_valid && out_ready) begin
            check(out_data == expw[got], "R4", "word order", out_data, expw[got]);
            check(out_last == (got == cnt - 1), "R4", "last flag", 32'(out_last), 32'(got == cnt - 1));
            check(32'(msg_bytes) == 32'(cnt * 4), "R4", "byte length", 32'(msg_bytes), 32'(cnt * 4));
            got++;
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
      check(got == cnt, "R4", "word count", 32'(got), 32'(cnt));
      check(busy == 1'b0, "R7", "busy after final word", 32'(busy), 32'd0);
      check(log_n - start == 2 * cnt, "R3", "bus transaction count", 32'(log_n - start), 32'(2 * cnt));
      for (int j = 0; j < cnt; j++) begin
         check(log_win[start + 2*j] == base + j && log_sel[start + 2*j] == 0, "R2",
               "ascending raw read", 32'(log_win[start + 2*j]), 32'(base + j));
         check(log_win[start + 2*j + 1] == base + j && log_sel[start + 2*j + 1] == 1 &&
               log_wd[start + 2*j + 1] == ONES, "R3", "clear after read",
               32'(log_win[start + 2*j + 1]), 32'(base + j));
         check(stat_mem[base + j] == 32'd0, "R3", "window emptied", stat_mem[base + j], 32'd0);
      end
      check(log_win[start + 2*cnt - 1] == base + cnt - 1, "R3", "final op clears last window",
            32'(log_win[start + 2*cnt - 1]), 32'(base + cnt - 1));
   endtask

   initial begin
      int start;
      logic [20:0] v;
      for (int w = 0; w < NUM_WIN; w++) begin
         stat_mem[w] = 32'd0;
         mask_mem[w] = ONES;
      end
      repeat (3) @(negedge clk);
      check(!busy && !bus_req && !out_valid, "R1", "reset state",
            {29'd0, busy, bus_req, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: drains under several group shapes, stalls and ready patterns
      for (int i = 0; i < VEC_N; i++) begin
         v = VECS[i];
         stall_en = v[0];
         run_drain(int'(v[20:16]), int'(v[15:12]), v[11:4], i + 1);
      end

      // R6: word held while downstream stalls
      stall_en = 1'b1;
      stat_mem[1] = 32'h1111_0001; stat_mem[2] = 32'h2222_0002;
      issue(2'd0, 1, 2);
      start = 0;
      while (!out_valid && start < 500) begin @(negedge clk); start++; end
      repeat (4) @(negedge clk);
      check(out_valid && out_data == 32'h2222_0002, "R6", "held word", out_data, 32'h2222_0002);
      out_ready = 1'b1;
      @(negedge clk);
      check(out_data == 32'h1111_0001 && out_last, "R6", "second word after release", out_data, 32'h1111_0001);
      @(negedge clk);
      out_ready = 1'b0;

      // R7: command while busy is ignored
      stat_mem[5] = 32'h5555_0005; stat_mem[6] = 32'h6666_0006;
      mask_mem[0] = ONES;
      issue(2'd0, 5, 2);
      start = 0;
      while (!out_valid && start < 500) begin @(negedge clk); start++; end
      start = log_n;
      issue(2'd1, 0, 1);
      repeat (3) @(negedge clk);
      check(log_n == start, "R7", "no bus op while busy", 32'(log_n - start), 32'd0);
      check(mask_mem[0] == ONES, "R7", "mask untouched", mask_mem[0], ONES);
      check(busy && out_valid && out_data == 32'h6666_0006, "R7", "drain still pending", out_data, 32'h6666_0006);
      out_ready = 1'b1;
      repeat (2) @(negedge clk);
      out_ready = 1'b0;
      @(negedge clk);
      check(!busy, "R7", "idle after delivery", 32'(busy), 32'd0);

      // R8: unmask only the last window of group 4..6
      start = log_n;
      issue(2'd1, 4, 3);
      while (busy) @(negedge clk);
      check(log_n - start == 1, "R8", "single bus op", 32'(log_n - start), 32'd1);
      check(log_win[start] == 6 && log_sel[start] == 3 && log_wd[start] == ONES, "R8",
            "mask-clear on last window", 32'(log_win[start]), 32'd6);
      check(mask_mem[6] == 32'd0 && mask_mem[5] == ONES && mask_mem[4] == ONES, "R8",
            "only last window unmasked", mask_mem[6], 32'd0);

      // R9: re-mask it
      start = log_n;
      issue(2'd2, 4, 3);
      while (busy) @(negedge clk);
      check(log_n - start == 1 && log_win[start] == 6 && log_sel[start] == 2, "R9",
            "mask-set on last window", 32'(log_sel[start]), 32'd2);
      check(mask_mem[6] == ONES, "R9", "window masked again", mask_mem[6], ONES);

      // R10: rejected commands
      start = log_n;
      issue(2'd0, 3, 0);
      check(!busy, "R10", "zero count", 32'(busy), 32'd0);
      issue(2'd0, 0, 9);
      check(!busy, "R10", "count above max", 32'(busy), 32'd0);
      issue(2'd0, 12, 5);
      check(!busy, "R10", "group past last window", 32'(busy), 32'd0);
      issue(2'd3, 2, 2);
      check(!busy, "R10", "reserved opcode", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
      check(log_n == start, "R10", "no bus activity", 32'(log_n - start), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk_cnt++;
         fail_cnt++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
         $finish;
      end
   end

endmodule